// File: doc/BRIEF.md
# Event Timer Register Front End and Main Counter

This block is the software-facing side of a multi-timer event generator. A 32-bit access port covers a 1 KB address window. The low part of the window holds the global registers: a fixed capability word pair, a configuration word, an interrupt status word and the 64-bit main counter. The upper part holds one 32-byte register set per timer. The block owns the capability, configuration and counter storage itself. For the per-timer sets it only decodes the access: it raises a one-cycle write strobe towards the owning timer and multiplexes that timer's read word back onto the port. The comparator and interrupt logic live elsewhere and consume these strobes and the live counter.

The main counter advances by one per clock while the global enable bit is set. When the bit is cleared, the counter freezes and holds its value. Software can rewrite either 32-bit half at any time. Reads return data combinationally in the cycle of the access. A read of the upper counter half shows the live counter bits, with no snapshot taken.

Top module: `etm_regblock`

## Requirements
- R1: After reset the main counter is zero, both configuration bits are zero and no write strobe is active.
- R2: The low capability word at 0x000 reads {16'h8086, 8'hA0 with bits 12:8 replaced by the timer count minus one, 8'h01}, which is 0x8086A201 for three timers. The high capability word at 0x004 reads the tick period in femtoseconds. Writes to either word change nothing that is read back.
- R3: In the configuration word at 0x010, only bit 0 (counter enable, driven on `count_en`) and bit 1 (legacy routing, driven on `legacy_route`) are stored. All other bits read zero. The word at 0x014 always reads zero and ignores writes.
- R4: While enable is 1 the counter increments by exactly one per clock. While enable is 0 it holds its value.
- R5: A write to 0x0F0 replaces counter bits 31:0 and a write to 0x0F4 replaces bits 63:32. The other half is unchanged, and a counter write takes precedence over the increment in that cycle.
- R6: A read returns its data in the same cycle as the access. A read of 0x0F4 returns bits 63:32 of the live counter.
- R7: A write to timer set i (base 0x100 + 0x20*i) raises exactly one one-cycle strobe for timer i, chosen by word offset: +0x0 config, +0x8 comparator low, +0xC comparator high, +0x10 route low, +0x14 route high. Offsets +0x4, +0x18 and +0x1C raise no strobe, and reads raise none.
- R8: Accesses to a timer index at or above the implemented count read zero and raise no strobe.
- R9: A read inside an implemented timer set drives `tmr_word` with address bits 4:2. For offsets +0x0 to +0x14 it returns that timer's slice of `tmr_rdata`. Offsets +0x18 and +0x1C read zero.
- R10: The status word at 0x020 reads `status_in` zero-extended. A write there pulses `status_clr_we` with `status_clr_mask` equal to the low written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 10 | Byte address in the window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, same cycle |
| tmr_word | output | 3 | Word index inside the addressed timer set |
| tmr_rdata | input | NT*32 | Read word offered by each timer |
| tmr_cfg_we | output | NT | Timer config write strobes |
| tmr_cmp_lo_we | output | NT | Comparator low write strobes |
| tmr_cmp_hi_we | output | NT | Comparator high write strobes |
| tmr_route_lo_we | output | NT | Route low write strobes |
| tmr_route_hi_we | output | NT | Route high write strobes |
| status_in | input | NT | Interrupt status from timers |
| status_clr_we | output | 1 | Status write pulse |
| status_clr_mask | output | NT | Bits written to status |
| count_en | output | 1 | Global enable |
| legacy_route | output | 1 | Legacy routing select |
| main_count | output | 64 | Live main counter |

## Verification
The hardest situation to reach is a carry from the low counter half into the high half while the counter runs. Counting there from reset would take billions of cycles. The stimulus preloads the low half to just below its wrap point while the counter is stopped, then enables it and reads the upper half live. A second hard spot is the boundary between implemented and absent timer sets. Seeded random addresses across the whole timer region are mixed with directed hits on the first absent set.

// File: rtl/etm_pkg.sv
package etm_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 10;

  localparam logic [ADDR_W-1:0] OFS_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] OFS_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] OFS_CFG_LO = 10'h010;
  localparam logic [ADDR_W-1:0] OFS_CFG_HI = 10'h014;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 10'h020;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 10'h0F4;

  localparam int unsigned CFG_BITS = 2;
  localparam logic [CFG_BITS-1:0] CFG_WMASK = 2'b11;

  typedef enum logic [2:0] {
    TW_CFG    = 3'd0,
    TW_CAP    = 3'd1,
    TW_CMP_LO = 3'd2,
    TW_CMP_HI = 3'd3,
    TW_RT_LO  = 3'd4,
    TW_RT_HI  = 3'd5,
    TW_RSV6   = 3'd6,
    TW_RSV7   = 3'd7
  } tmr_word_e;

  typedef enum logic [3:0] {
    GS_NONE, GS_CAP_LO, GS_CAP_HI, GS_CFG_LO, GS_CFG_HI,
    GS_STAT, GS_CNT_LO, GS_CNT_HI, GS_TMR
  } reg_sel_e;
endpackage

// File: rtl/etm_rst_sync.sv
module etm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/etm_decode.sv
module etm_decode
  import etm_pkg::*;
#(
  parameter int unsigned NT = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [4:0]        tmr_idx,
  output tmr_word_e         word,
  output logic              tmr_hit
);
  logic [ADDR_W-1:0] word_addr;

  assign word_addr = {addr[ADDR_W-1:2], 2'b00};
  assign tmr_idx   = addr[9:5] - 5'd8;
  assign word      = tmr_word_e'(addr[4:2]);

  always_comb begin
    sel     = GS_NONE;
    tmr_hit = 1'b0;
    if (addr[9:8] != 2'b00) begin
      sel     = GS_TMR;
      tmr_hit = ({1'b0, tmr_idx} < 6'(NT));
    end else begin
      case (word_addr)
        OFS_CAP_LO: sel = GS_CAP_LO;
        OFS_CAP_HI: sel = GS_CAP_HI;
        OFS_CFG_LO: sel = GS_CFG_LO;
        OFS_CFG_HI: sel = GS_CFG_HI;
        OFS_STAT:   sel = GS_STAT;
        OFS_CNT_LO: sel = GS_CNT_LO;
        OFS_CNT_HI: sel = GS_CNT_HI;
        default:    sel = GS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/etm_counter.sv
module etm_counter
  import etm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] count
);
  localparam int unsigned CW = 2 * DATA_W;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = wr_lo | wr_hi | en;
    if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_d[DATA_W-1:0]  = wdata;
      if (wr_hi) cnt_d[CW-1:DATA_W] = wdata;
    end else if (en) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/etm_readmux.sv
module etm_readmux
  import etm_pkg::*;
#(
  parameter int unsigned NT = 3
) (
  input  reg_sel_e             sel,
  input  logic                 tmr_hit,
  input  logic [4:0]           tmr_idx,
  input  tmr_word_e            word,
  input  logic [DATA_W-1:0]    cap_lo,
  input  logic [DATA_W-1:0]    cap_hi,
  input  logic [CFG_BITS-1:0]  cfg,
  input  logic [NT-1:0]        status_in,
  input  logic [2*DATA_W-1:0]  count,
  input  logic [NT*DATA_W-1:0] tmr_rdata,
  output logic [DATA_W-1:0]    rdata
);
  logic [DATA_W-1:0] tmr_arr [NT];
  logic [DATA_W-1:0] tmr_pick;

  for (genvar i = 0; i < NT; i++) begin : g_slice
    assign tmr_arr[i] = tmr_rdata[i*DATA_W +: DATA_W];
  end

  always_comb begin
    tmr_pick = '0;
    for (int i = 0; i < NT; i++) begin
      if (tmr_idx == 5'(i)) tmr_pick = tmr_arr[i];
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      GS_CAP_LO: rdata = cap_lo;
      GS_CAP_HI: rdata = cap_hi;
      GS_CFG_LO: rdata = DATA_W'(cfg);
      GS_STAT:   rdata = DATA_W'(status_in);
      GS_CNT_LO: rdata = count[DATA_W-1:0];
      GS_CNT_HI: rdata = count[2*DATA_W-1:DATA_W];
      GS_TMR:    if (tmr_hit && word != TW_RSV6 && word != TW_RSV7) rdata = tmr_pick;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/etm_regblock.sv
module etm_regblock
  import etm_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 3,
  parameter logic [15:0] VENDOR_ID  = 16'h8086,
  parameter logic [31:0] TICK_FS    = 32'd10_000_000,
  localparam int unsigned NT = (NUM_TIMERS < 3) ? 3 : ((NUM_TIMERS > 32) ? 32 : NUM_TIMERS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [9:0]           acc_addr,
  input  logic [31:0]          acc_wdata,
  output logic [31:0]          acc_rdata,
  output logic [2:0]           tmr_word,
  input  logic [NT*32-1:0]     tmr_rdata,
  output logic [NT-1:0]        tmr_cfg_we,
  output logic [NT-1:0]        tmr_cmp_lo_we,
  output logic [NT-1:0]        tmr_cmp_hi_we,
  output logic [NT-1:0]        tmr_route_lo_we,
  output logic [NT-1:0]        tmr_route_hi_we,
  input  logic [NT-1:0]        status_in,
  output logic                 status_clr_we,
  output logic [NT-1:0]        status_clr_mask,
  output logic                 count_en,
  output logic                 legacy_route,
  output logic [63:0]          main_count
);
  localparam logic [4:0] NT_M1 = 5'(NT - 1);

  logic              rst_q_n;
  reg_sel_e          sel;
  logic [4:0]        tmr_idx;
  tmr_word_e         word;
  logic              tmr_hit;
  logic              wr_any;
  logic [CFG_BITS-1:0] cfg_q, cfg_d;
  logic              cfg_ce;
  logic [DATA_W-1:0] cap_lo, cap_hi;

  etm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  etm_decode #(.NT(NT)) u_dec (
    .addr(acc_addr), .sel(sel), .tmr_idx(tmr_idx), .word(word), .tmr_hit(tmr_hit)
  );

  assign wr_any = acc_valid & acc_write;

  // configuration word: next state then register
  always_comb begin
    cfg_ce = wr_any && (sel == GS_CFG_LO);
    cfg_d  = (acc_wdata[CFG_BITS-1:0] & CFG_WMASK) | (cfg_q & ~CFG_WMASK);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    cfg_q <= '0;
    else if (cfg_ce) cfg_q <= cfg_d;
  end

  assign count_en     = cfg_q[0];
  assign legacy_route = cfg_q[1];

  etm_counter u_cnt (
    .clk(clk), .rst_n(rst_q_n), .en(count_en),
    .wr_lo(wr_any && sel == GS_CNT_LO),
    .wr_hi(wr_any && sel == GS_CNT_HI),
    .wdata(acc_wdata), .count(main_count)
  );

  assign cap_lo = {VENDOR_ID, 1'b1, 1'b0, 1'b1, NT_M1, 8'h01};
  assign cap_hi = TICK_FS;

  etm_readmux #(.NT(NT)) u_rmux (
    .sel(sel), .tmr_hit(tmr_hit), .tmr_idx(tmr_idx), .word(word),
    .cap_lo(cap_lo), .cap_hi(cap_hi), .cfg(cfg_q), .status_in(status_in),
    .count(main_count), .tmr_rdata(tmr_rdata), .rdata(acc_rdata)
  );

  assign tmr_word = word;

  for (genvar i = 0; i < NT; i++) begin : g_strobe
    logic hit_i;
    assign hit_i              = wr_any && (sel == GS_TMR) && tmr_hit && (tmr_idx == 5'(i));
    assign tmr_cfg_we[i]      = hit_i && (word == TW_CFG);
    assign tmr_cmp_lo_we[i]   = hit_i && (word == TW_CMP_LO);
    assign tmr_cmp_hi_we[i]   = hit_i && (word == TW_CMP_HI);
    assign tmr_route_lo_we[i] = hit_i && (word == TW_RT_LO);
    assign tmr_route_hi_we[i] = hit_i && (word == TW_RT_HI);
  end

  assign status_clr_we   = wr_any && (sel == GS_STAT);
  assign status_clr_mask = acc_wdata[NT-1:0];
endmodule

// File: rtl/etm_regblock_chk.sv
module etm_regblock_chk #(
  parameter int unsigned NT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [9:0]    acc_addr,
  input logic [31:0]   acc_wdata,
  input logic [31:0]   acc_rdata,
  input logic [NT-1:0] tmr_cfg_we,
  input logic [NT-1:0] tmr_cmp_lo_we,
  input logic [NT-1:0] tmr_cmp_hi_we,
  input logic [NT-1:0] tmr_route_lo_we,
  input logic [NT-1:0] tmr_route_hi_we,
  input logic          count_en,
  input logic [63:0]   main_count
);
  logic          wr_cnt_lo, wr_cnt_hi, oob;
  logic [5*NT-1:0] all_we;

  assign wr_cnt_lo = acc_valid && acc_write && (acc_addr[9:2] == 8'h3C);
  assign wr_cnt_hi = acc_valid && acc_write && (acc_addr[9:2] == 8'h3D);
  assign oob       = (acc_addr[9:8] != 2'b00) && ({1'b0, acc_addr[9:5]} >= 6'(NT + 8));
  assign all_we    = {tmr_cfg_we, tmr_cmp_lo_we, tmr_cmp_hi_we, tmr_route_lo_we, tmr_route_hi_we};

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(main_count));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !wr_cnt_lo && !wr_cnt_hi) |=> (main_count == $past(main_count) + 64'd1));

  a_r5_lo_half: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt_lo && !wr_cnt_hi) |=>
      (main_count[31:0] == $past(acc_wdata) && main_count[63:32] == $past(main_count[63:32])));

  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(all_we) <= 1);

  a_r7_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |-> (all_we == '0));

  a_r8_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && oob) |-> (all_we == '0 && acc_rdata == 32'd0));

  a_r3_cfg_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr[9:2] == 8'h05) |-> (acc_rdata == 32'd0));
endmodule

bind etm_regblock etm_regblock_chk #(.NT(NT)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
  .tmr_cfg_we(tmr_cfg_we), .tmr_cmp_lo_we(tmr_cmp_lo_we), .tmr_cmp_hi_we(tmr_cmp_hi_we),
  .tmr_route_lo_we(tmr_route_lo_we), .tmr_route_hi_we(tmr_route_hi_we),
  .count_en(count_en), .main_count(main_count)
);

// File: tb/etm_regblock_test.sv
module etm_regblock_test;
  localparam int NT = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, acc_write;
  logic [9:0] acc_addr;
  logic [31:0] acc_wdata, acc_rdata;
  logic [2:0] tmr_word;
  logic [NT*32-1:0] tmr_rdata;
  logic [NT-1:0] tmr_cfg_we, tmr_cmp_lo_we, tmr_cmp_hi_we, tmr_route_lo_we, tmr_route_hi_we;
  logic [NT-1:0] status_in, status_clr_mask;
  logic status_clr_we, count_en, legacy_route;
  logic [63:0] main_count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  etm_regblock uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .tmr_word(tmr_word), .tmr_rdata(tmr_rdata),
    .tmr_cfg_we(tmr_cfg_we), .tmr_cmp_lo_we(tmr_cmp_lo_we), .tmr_cmp_hi_we(tmr_cmp_hi_we),
    .tmr_route_lo_we(tmr_route_lo_we), .tmr_route_hi_we(tmr_route_hi_we),
    .status_in(status_in), .status_clr_we(status_clr_we), .status_clr_mask(status_clr_mask),
    .count_en(count_en), .legacy_route(legacy_route), .main_count(main_count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    #1 d = acc_rdata;
  endtask

  function automatic logic [31:0] exp_tmr_read(input logic [9:0] a, input logic [NT*32-1:0] rd_in);
    int idx = int'(a[9:5]) - 8;
    if (idx >= NT || a[4:2] >= 3'd6) return 32'd0;
    return rd_in[idx*32 +: 32];
  endfunction

  function automatic logic [5*NT-1:0] exp_we(input logic [9:0] a, input logic w);
    logic [NT-1:0] c = '0, cl = '0, ch = '0, rl = '0, rh = '0;
    int idx = int'(a[9:5]) - 8;
    if (w && idx < NT) begin
      case (a[4:2])
        3'd0: c[idx]  = 1'b1;
        3'd2: cl[idx] = 1'b1;
        3'd3: ch[idx] = 1'b1;
        3'd4: rl[idx] = 1'b1;
        3'd5: rh[idx] = 1'b1;
        default: ;
      endcase
    end
    return {c, cl, ch, rl, rh};
  endfunction

  function automatic logic [5*NT-1:0] got_we();
    return {tmr_cfg_we, tmr_cmp_lo_we, tmr_cmp_hi_we, tmr_route_lo_we, tmr_route_hi_we};
  endfunction

  task automatic tmr_access(input logic [9:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
    #1;
    chk(w ? "R7 strobes" : "R7 no strobe on read", 64'(got_we()), 64'(exp_we(a, w)));
    if (!w) begin
      chk("R9/R8 timer readback", 64'(acc_rdata), 64'(exp_tmr_read(a, tmr_rdata)));
      chk("R9 word index", 64'(tmr_word), 64'(a[4:2]));
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v1, v2;
    void'($urandom(32'd1234));
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_wdata = '0;
    tmr_rdata = '0; status_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 counter", main_count, 64'd0);
    chk("R1 enable", 64'(count_en), 64'd0);
    chk("R1 legacy", 64'(legacy_route), 64'd0);
    chk("R1 strobes", 64'(got_we()), 64'd0);

    // R2 capability
    rd(10'h000, v1); chk("R2 cap lo", 64'(v1), 64'h8086A201);
    rd(10'h004, v1); chk("R2 cap hi", 64'(v1), 64'd10_000_000);
    wr(10'h000, 32'hFFFF_FFFF); wr(10'h004, 32'h0);
    rd(10'h000, v1); chk("R2 cap lo after write", 64'(v1), 64'h8086A201);
    rd(10'h004, v1); chk("R2 cap hi after write", 64'(v1), 64'd10_000_000);

    // R3 configuration
    wr(10'h010, 32'hFFFF_FFFC);
    rd(10'h010, v1); chk("R3 unwritable bits", 64'(v1), 64'd0);
    wr(10'h010, 32'h0000_0002);
    rd(10'h010, v1); chk("R3 legacy bit", 64'(v1), 64'd2);
    chk("R3 legacy_route pin", 64'(legacy_route), 64'd1);
    chk("R3 enable pin", 64'(count_en), 64'd0);
    wr(10'h014, 32'hFFFF_FFFF);
    rd(10'h014, v1); chk("R3 upper cfg word", 64'(v1), 64'd0);
    rd(10'h010, v1); chk("R3 cfg unchanged by upper write", 64'(v1), 64'd2);
    wr(10'h010, 32'h0);

    // R5 halves while stopped, R4 hold
    wr(10'h0F0, 32'h1234_5678);
    wr(10'h0F4, 32'hCAFE_F00D);
    rd(10'h0F0, v1); chk("R5 low half", 64'(v1), 64'h1234_5678);
    rd(10'h0F4, v1); chk("R5 high half", 64'(v1), 64'hCAFE_F00D);
    wr(10'h0F4, 32'h0000_0011);
    rd(10'h0F0, v1); chk("R5 low kept on high write", 64'(v1), 64'h1234_5678);
    repeat (20) @(negedge clk);
    chk("R4 hold while disabled", main_count, 64'h0000_0011_1234_5678);

    // R4/R6 running, carry into upper half
    wr(10'h0F0, 32'hFFFF_FFF0);
    wr(10'h0F4, 32'h0000_0005);
    wr(10'h010, 32'h1);
    repeat (40) @(negedge clk);
    rd(10'h0F4, v1); chk("R6 live high half after carry", 64'(v1), 64'd6);
    rd(10'h0F0, v1);
    repeat (10) @(negedge clk);
    rd(10'h0F0, v2); chk("R4 one step per clock", 64'(v2 - v1), 64'd11);
    wr(10'h010, 32'h0);
    rd(10'h0F0, v1);
    repeat (15) @(negedge clk);
    rd(10'h0F0, v2); chk("R4 frozen after disable", 64'(v2), 64'(v1));
    acc_valid = 1'b0;

    // R10 status
    status_in = 3'b101;
    rd(10'h020, v1); chk("R10 status read", 64'(v1), 64'd5);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 10'h020; acc_wdata = 32'hFFFF_FFFE;
    #1;
    chk("R10 clear pulse", 64'(status_clr_we), 64'd1);
    chk("R10 clear mask", 64'(status_clr_mask), 64'd6);
    @(negedge clk); acc_valid = 1'b0; #1;
    chk("R10 pulse ends", 64'(status_clr_we), 64'd0);

    // directed timer corners
    tmr_rdata = {32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000};
    tmr_access(10'h14C, 1'b1, 32'h1);   // R7 timer 2 comparator high
    tmr_access(10'h104, 1'b1, 32'h1);   // R7 capability offset: no strobe
    tmr_access(10'h160, 1'b1, 32'h1);   // R8 first absent timer
    tmr_access(10'h160, 1'b0, 32'h0);   // R8 read zero
    tmr_access(10'h128, 1'b0, 32'h0);   // R9 timer 1
    tmr_access(10'h138, 1'b0, 32'h0);   // R9 reserved word reads zero

    // seeded random timer-region traffic
    for (int i = 0; i < 400; i++) begin
      tmr_rdata = {$urandom, $urandom, $urandom};
      tmr_access(10'h100 + 10'(($urandom % 192) * 4), 1'($urandom), $urandom);
    end
    @(negedge clk); acc_valid = 1'b0; acc_write = 1'b0;
    #1 chk("R7 idle no strobe", 64'(got_we()), 64'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule